// File: doc/BRIEF.md
# Serial Control-Port Register File

This block is the write-only control port of an audio codec. A host drives three wires: an active-low chip select, a serial clock and a serial data line. While chip select is low, each rising serial clock edge shifts in one bit. A complete access carries sixteen bits: an 8-bit register address followed by an 8-bit value, each sent most significant bit first. When chip select is released after exactly sixteen bits, the value is stored in one of sixteen 8-bit control registers. These registers hold the per-channel volumes, the mixer switch settings, the reset and power-down controls and the microphone gain.

The three serial pins are sampled in the chip's own clock domain through two-flop synchronizers, so the serial clock must be slow compared with `clk`. Only the low five address bits are decoded, so the register map repeats every 32 addresses. A write to an unmapped address is dropped without any effect. The reserved test address is never written. Every stored value is presented on its own parallel output, and bit positions a register does not use always read as zero.

Top module: `codec_ctl_port`

## Requirements
- R1: While `cs_n` is low, `sdi` is sampled on each rising edge of `sclk`. The first eight bits form the address (bit 7 first) and the next eight form the data (bit 7 first). The register is updated no later than four `clk` cycles after `cs_n` rises, provided each `sclk` level and the `cs_n` setup and hold each last at least three `clk` cycles.
- R2: A frame is committed only if exactly 16 bits were received before `cs_n` rose. Frames with 0 to 15 bits, or with 17 or more bits, leave every output unchanged.
- R3: Address bits 7 to 5 are ignored. For example, a write to 0x20, 0x40 or 0xE0 updates the register at 0x00.
- R4: After aliasing, the mapped addresses and their outputs are: 0x00 `master_l`, 0x01 `master_r`, 0x02 `voice_l`, 0x03 `voice_r`, 0x08 `line_l`, 0x09 `line_r`, 0x0A `aux_l`, 0x0B `aux_r`, 0x10 `mix_out1`, 0x11 `mix_out2`, 0x12 `mix_in_l1`, 0x13 `mix_in_r1`, 0x14 `mix_in_l2`, 0x15 `mix_in_r2`, 0x16 `pwr_ctl`, 0x19 `mic_gain`. A write to any other address changes no output.
- R5: A write to 0x1A, or to any of its aliases, changes no output.
- R6: Each register keeps only the bits it uses, and all other bits read as 0. The volume registers keep bit 7 (mute, 1 = muted) and bits 4:0 (level code, mask 0x9F). For master volume, code 0 means 0 dB and code 31 means -62 dB, in 2 dB steps. The masks of the other registers are: `mix_out1` 0x07, `mix_out2` 0x0F, `mix_in_l1` and `mix_in_r1` 0x03, `mix_in_l2` and `mix_in_r2` 0x07, `pwr_ctl` 0x03, `mic_gain` 0x01.
- R7: A synchronous active-high `rst` clears every register to 0x00 and discards any frame in progress. A frame that was partly received when reset arrived does not commit when `cs_n` later rises.
- R8: A rising `sclk` edge that is sampled in the same `clk` cycle as the rise of `cs_n` is not counted as a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial data input |
| master_l | output | 8 | Master volume, left |
| master_r | output | 8 | Master volume, right |
| voice_l | output | 8 | Voice volume, left |
| voice_r | output | 8 | Voice volume, right |
| line_l | output | 8 | Line volume, left |
| line_r | output | 8 | Line volume, right |
| aux_l | output | 8 | Aux volume, left |
| aux_r | output | 8 | Aux volume, right |
| mix_out1 | output | 8 | Output mixer switches, group 1 |
| mix_out2 | output | 8 | Output mixer switches, group 2 |
| mix_in_l1 | output | 8 | Left input mixer switches, group 1 |
| mix_in_r1 | output | 8 | Right input mixer switches, group 1 |
| mix_in_l2 | output | 8 | Left input mixer switches, group 2 |
| mix_in_r2 | output | 8 | Right input mixer switches, group 2 |
| pwr_ctl | output | 8 | Reset and power-down controls |
| mic_gain | output | 8 | Microphone amplifier gain select |

## Verification
The release of chip select and a rising serial clock edge can be sampled in the same `clk` cycle. In that case the edge must not be counted. The bench provokes this by raising `sclk` and `cs_n` together, once after fifteen bits and once after sixteen bits. The expected outcome is that the first frame is discarded and the second commits, because the coincident edge neither completes the short frame nor spoils the full one. In both cases the bench compares all sixteen parallel outputs against its own model after the release.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

    localparam int REG_W      = 8;
    localparam int ADDR_W     = 8;
    localparam int FRAME_BITS = ADDR_W + REG_W;
    localparam int DEC_W      = 5;
    localparam int NUM_SLOTS  = 16;
    localparam int SLOT_W     = $clog2(NUM_SLOTS);
    localparam int CNT_MAX    = FRAME_BITS + 1;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    localparam logic [DEC_W-1:0] TEST_ADDR = 5'h1A;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [REG_W-1:0]  reg_t;

    typedef struct packed {
        logic  hit;
        slot_t idx;
    } slot_sel_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        reg_t              data;
    } frame_t;

    localparam int SL_MASTER_L = 0;
    localparam int SL_MASTER_R = 1;
    localparam int SL_VOICE_L  = 2;
    localparam int SL_VOICE_R  = 3;
    localparam int SL_LINE_L   = 4;
    localparam int SL_LINE_R   = 5;
    localparam int SL_AUX_L    = 6;
    localparam int SL_AUX_R    = 7;
    localparam int SL_MIX_O1   = 8;
    localparam int SL_MIX_O2   = 9;
    localparam int SL_MIX_IL1  = 10;
    localparam int SL_MIX_IR1  = 11;
    localparam int SL_MIX_IL2  = 12;
    localparam int SL_MIX_IR2  = 13;
    localparam int SL_PWR      = 14;
    localparam int SL_MIC      = 15;

    // Decoded (aliased) address to storage slot; the test location is a miss.
    function automatic slot_sel_t slot_lookup(input logic [DEC_W-1:0] a);
        slot_sel_t s;
        s.hit = 1'b1;
        s.idx = '0;
        if (a <= 5'h03)                     s.idx = slot_t'(a);
        else if (a >= 5'h08 && a <= 5'h0B)  s.idx = slot_t'(a - 5'h04);
        else if (a >= 5'h10 && a <= 5'h16)  s.idx = slot_t'(a - 5'h08);
        else if (a == 5'h19)                s.idx = slot_t'(SL_MIC);
        else                                s.hit = 1'b0;
        return s;
    endfunction

    // Bits kept by each slot.
    function automatic reg_t slot_mask(input int s);
        reg_t m;
        if (s <= SL_AUX_R)                         m = 8'h9F;
        else if (s == SL_MIX_O1)                   m = 8'h07;
        else if (s == SL_MIX_O2)                   m = 8'h0F;
        else if (s == SL_MIX_IL1 || s == SL_MIX_IR1) m = 8'h03;
        else if (s == SL_MIX_IL2 || s == SL_MIX_IR2) m = 8'h07;
        else if (s == SL_PWR)                      m = 8'h03;
        else                                       m = 8'h01;
        return m;
    endfunction

endpackage

// File: rtl/ctl_serial_rx.sv
module ctl_serial_rx
    import codec_ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n,
    input  logic   sclk,
    input  logic   sdi,
    output logic   frame_v,
    output frame_t frame
);

    localparam int SYNC_N = 2;

    logic [SYNC_N-1:0] cs_sync, ck_sync, d_sync;
    logic              cs_prev, ck_prev;
    logic [CNT_W-1:0]  bit_cnt;
    logic [FRAME_BITS-1:0] shreg;

    wire cs_s   = cs_sync[SYNC_N-1];
    wire ck_s   = ck_sync[SYNC_N-1];
    wire d_s    = d_sync[SYNC_N-1];
    wire ck_up  = ck_s & ~ck_prev;
    wire cs_up  = cs_s & ~cs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_sync <= '1;
            ck_sync <= '0;
            d_sync  <= '0;
            cs_prev <= 1'b1;
            ck_prev <= 1'b0;
        end else begin
            cs_sync <= {cs_sync[SYNC_N-2:0], cs_n};
            ck_sync <= {ck_sync[SYNC_N-2:0], sclk};
            d_sync  <= {d_sync[SYNC_N-2:0], sdi};
            cs_prev <= cs_s;
            ck_prev <= ck_s;
        end
    end

    // Count saturates one past a full frame so overlong frames are rejected.
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (cs_s) begin
            bit_cnt <= '0;
        end else if (ck_up) begin
            shreg <= {shreg[FRAME_BITS-2:0], d_s};
            if (bit_cnt != CNT_W'(CNT_MAX))
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign frame_v = cs_up && (bit_cnt == CNT_W'(FRAME_BITS));
    assign frame   = frame_t'(shreg);

    a_r2_count_capped: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(CNT_MAX));

    a_r7_idle_clears_count: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> (bit_cnt == '0));

    a_r8_no_count_on_release: assert property (@(posedge clk) disable iff (rst)
        (cs_s && ck_up) |=> (bit_cnt == '0));

endmodule

// File: rtl/ctl_addr_map.sv
module ctl_addr_map
    import codec_ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_v,
    input  frame_t frame,
    output logic   wr_en,
    output slot_t  wr_slot,
    output reg_t   wr_data
);

    slot_sel_t sel;
    logic [DEC_W-1:0] dec_addr;

    assign dec_addr = frame.addr[DEC_W-1:0];
    assign sel      = slot_lookup(dec_addr);
    assign wr_en    = frame_v && sel.hit;
    assign wr_slot  = sel.idx;
    assign wr_data  = frame.data;

    a_r5_test_addr_blocked: assert property (@(posedge clk) disable iff (rst)
        (frame_v && dec_addr == TEST_ADDR) |-> !wr_en);

    a_r2_write_needs_frame: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> frame_v);

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
    import codec_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  slot_t wr_slot,
    input  reg_t  wr_data,
    output reg_t  reg_q [NUM_SLOTS]
);

    logic [NUM_SLOTS*REG_W-1:0] flat;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam reg_t MASK = slot_mask(i);

        always_ff @(posedge clk) begin
            if (rst)
                reg_q[i] <= '0;
            else if (wr_en && wr_slot == slot_t'(i))
                reg_q[i] <= wr_data & MASK;
        end

        assign flat[i*REG_W +: REG_W] = reg_q[i];

        a_r6_unused_zero: assert property (@(posedge clk) disable iff (rst)
            (reg_q[i] & ~MASK) == '0);
    end

    a_r1_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(flat));

endmodule

// File: rtl/codec_ctl_port.sv
module codec_ctl_port
    import codec_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       sdi,
    output logic [7:0] master_l,
    output logic [7:0] master_r,
    output logic [7:0] voice_l,
    output logic [7:0] voice_r,
    output logic [7:0] line_l,
    output logic [7:0] line_r,
    output logic [7:0] aux_l,
    output logic [7:0] aux_r,
    output logic [7:0] mix_out1,
    output logic [7:0] mix_out2,
    output logic [7:0] mix_in_l1,
    output logic [7:0] mix_in_r1,
    output logic [7:0] mix_in_l2,
    output logic [7:0] mix_in_r2,
    output logic [7:0] pwr_ctl,
    output logic [7:0] mic_gain
);

    logic   frame_v;
    frame_t frame;
    logic   wr_en;
    slot_t  wr_slot;
    reg_t   wr_data;
    reg_t   reg_q [NUM_SLOTS];

    ctl_serial_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .sdi     (sdi),
        .frame_v (frame_v),
        .frame   (frame)
    );

    ctl_addr_map u_map (
        .clk     (clk),
        .rst     (rst),
        .frame_v (frame_v),
        .frame   (frame),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (wr_data)
    );

    ctl_reg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .reg_q   (reg_q)
    );

    assign master_l  = reg_q[SL_MASTER_L];
    assign master_r  = reg_q[SL_MASTER_R];
    assign voice_l   = reg_q[SL_VOICE_L];
    assign voice_r   = reg_q[SL_VOICE_R];
    assign line_l    = reg_q[SL_LINE_L];
    assign line_r    = reg_q[SL_LINE_R];
    assign aux_l     = reg_q[SL_AUX_L];
    assign aux_r     = reg_q[SL_AUX_R];
    assign mix_out1  = reg_q[SL_MIX_O1];
    assign mix_out2  = reg_q[SL_MIX_O2];
    assign mix_in_l1 = reg_q[SL_MIX_IL1];
    assign mix_in_r1 = reg_q[SL_MIX_IR1];
    assign mix_in_l2 = reg_q[SL_MIX_IL2];
    assign mix_in_r2 = reg_q[SL_MIX_IR2];
    assign pwr_ctl   = reg_q[SL_PWR];
    assign mic_gain  = reg_q[SL_MIC];

    a_r7_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (master_l == '0 && mic_gain == '0 && pwr_ctl == '0));

endmodule

// File: tb/codec_ctl_port_tb_top.sv
`timescale 1ns/1ps
module codec_ctl_port_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic [7:0] got [16];
    logic [7:0] expv [16];
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    codec_ctl_port dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .master_l(got[0]), .master_r(got[1]), .voice_l(got[2]), .voice_r(got[3]),
        .line_l(got[4]), .line_r(got[5]), .aux_l(got[6]), .aux_r(got[7]),
        .mix_out1(got[8]), .mix_out2(got[9]), .mix_in_l1(got[10]), .mix_in_r1(got[11]),
        .mix_in_l2(got[12]), .mix_in_r2(got[13]), .pwr_ctl(got[14]), .mic_gain(got[15])
    );

    // Requirement tables (R4 addresses, R6 masks).
    function automatic int addr_of(input int i);
        int tbl [16] = '{0, 1, 2, 3, 8, 9, 10, 11, 16, 17, 18, 19, 20, 21, 22, 25};
        return tbl[i];
    endfunction

    function automatic logic [7:0] mask_of(input int i);
        logic [7:0] tbl [16] = '{8'h9F, 8'h9F, 8'h9F, 8'h9F, 8'h9F, 8'h9F, 8'h9F, 8'h9F,
                                 8'h07, 8'h0F, 8'h03, 8'h03, 8'h07, 8'h07, 8'h03, 8'h01};
        return tbl[i];
    endfunction

    function automatic int find_slot(input logic [7:0] a);
        int low = int'(a % 32);
        for (int i = 0; i < 16; i++)
            if (addr_of(i) == low) return i;
        return -1;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        int s = find_slot(a);
        if (s >= 0) expv[s] = d & mask_of(s);
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        bit bad = 1'b0;
        tests++;
        for (int i = 0; i < 16; i++) begin
            if (got[i] !== expv[i]) begin
                if (!bad)
                    $display("FAIL %s: output %0d actual %02h expected %02h",
                             req, i, got[i], expv[i]);
                bad = 1'b1;
            end
        end
        if (bad) fails++;
    endtask

    // nbits edges; coincide raises sclk together with cs_n at release.
    task automatic send(input logic [7:0] a, input logic [7:0] d,
                        input int nbits, input bit coincide);
        logic [15:0] fr = {a, d};
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? fr[15 - i] : 1'b0;
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(4);
        if (coincide) begin
            sdi  = 1'b1;
            sclk = 1'b1;
            cs_n = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(4);
        end else begin
            cs_n = 1'b1;
            wait_clk(8);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) expv[i] = 8'h00;
        wait_clk(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        wait_clk(1);
        do_reset();
        check_all("R7 reset state");

        // R3 R4 R5: every address with a varying data pattern
        for (int a = 0; a < 256; a++) begin
            d = 8'((a * 37 + 11) % 256);
            send(8'(a), d, 16, 1'b0);
            model_write(8'(a), d);
            if (a % 32 == 26) check_all("R5 test address");
            else if (a >= 32) check_all("R3 alias");
            else check_all("R4 map");
        end

        // R6: masks with all-ones and with unused-only bits
        for (int s = 0; s < 16; s++) begin
            send(8'(addr_of(s)), 8'hFF, 16, 1'b0);
            model_write(8'(addr_of(s)), 8'hFF);
            check_all("R6 mask ones");
            send(8'(addr_of(s) + 64), ~mask_of(s), 16, 1'b0);
            model_write(8'(addr_of(s)), ~mask_of(s));
            check_all("R6 unused bits zero");
        end
        send(8'h00, 8'h1F, 16, 1'b0);
        model_write(8'h00, 8'h1F);
        check_all("R6 master -62 dB code");
        send(8'h01, 8'h80, 16, 1'b0);
        model_write(8'h01, 8'h80);
        check_all("R6 master mute");

        // R2: wrong bit counts are discarded
        for (int n = 0; n <= 20; n++) begin
            if (n != 16) begin
                send(8'h00, 8'h55, n, 1'b0);
                check_all("R2 bit count");
            end
        end
        send(8'h00, 8'h15, 16, 1'b0);
        model_write(8'h00, 8'h15);
        check_all("R1 sixteen-bit commit");

        // R8: coincident edge on release is not counted
        send(8'h02, 8'h0A, 15, 1'b1);
        check_all("R8 coincident edge after 15 bits");
        send(8'h02, 8'h0A, 16, 1'b1);
        model_write(8'h02, 8'h0A);
        check_all("R8 coincident edge after 16 bits");

        // R7: reset mid-frame discards the frame
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < 8; i++) begin
            sdi = 1'b0;
            wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
        end
        do_reset();
        check_all("R7 reset clears registers");
        for (int i = 0; i < 8; i++) begin
            sdi = 1'b1;
            wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
        end
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
        check_all("R7 partial frame discarded");

        send(8'hF9, 8'hFF, 16, 1'b0);
        model_write(8'hF9, 8'hFF);
        check_all("R1 R3 final write");
        finish_run();
    end

endmodule